// File: doc/BRIEF.md
# Dual-Multiplier Accumulating Mixer

This block is a fully registered arithmetic datapath. It multiplies two pairs of signed 12-bit operands and combines the two 24-bit products by addition or subtraction. The combined value can be rounded, offset by a 16-bit chaining input, and either loaded into or added onto a 24-bit accumulator. The accumulator is read through a 16-bit port that shows either its upper or its lower word. The two words overlap by eight bits.

Each of the four operand ports has its own delay line and clock enable. Operands that arrive at different times can therefore be lined up before they reach the multipliers. A typical use is to mix two weighted signals, to build one rail of a complex product, or to chain several units through the chaining input to form a filter tap sum.

The block accepts a new operand set on every clock and produces a new accumulator value on every clock. There is no valid/ready handshake and no back-pressure. Operands are consumed on each edge at which their port enable is high. The output is never stalled. `out_vld` qualifies `out_word`.

Top module: `dual_mixer_core`

## Requirements
- R1: The accumulator input is P0 + P1 in 24-bit two's complement, where P0 = op_a*op_b and P1 = op_c*op_d are signed products. `inv_p0` replaces P0 by -P0 and `inv_p1` replaces P1 by -P1.
- R2: Each operand port has a 4-bit lag code c (`lag_a`..`lag_d`) that gives a delay of c+1 clocks. Count the edge that captures an operand as edge 1. The operand's contribution then appears in the accumulator after edge c+3.
- R3: While a port's `cke_*` is low, its delay line holds every stage, so the value that port feeds to its multiplier stays fixed.
- R4: The controls `inv_p0`, `inv_p1`, `round_en`, `accum_en`, `chain_en` and `chain_in` are registered at one edge and act on the accumulator write at the next edge. With `accum_en` set, the new value is the old accumulator plus the new sum. With it clear, the accumulator loads the new sum.
- R5: With `chain_en` set, `chain_in` is sign-extended to 24 bits and added at bit 0. With it clear, it contributes nothing.
- R6: With `round_en` set, 2^7 (half an LSB of the upper 16-bit word) is added, so that the upper word is rounded to nearest.
- R7: `hi_word` is registered. After the edge that samples it, `out_word` shows accumulator bits 23:8 when it is 1, and bits 15:0 when it is 0.
- R8: `out_en` acts without a clock. When it is low, `out_word` is 0 and `out_vld` is 0. When it is high, `out_vld` is 1.
- R9: A high `rst` at a clock edge clears the accumulator, all delay stages, the products and the registered controls. The output then reads 0.
- R10: The accumulator wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 12 | Multiplicand of product 0 |
| op_b | input | 12 | Multiplier of product 0 |
| op_c | input | 12 | Multiplicand of product 1 |
| op_d | input | 12 | Multiplier of product 1 |
| lag_a | input | 4 | Delay code for op_a (c gives c+1 clocks) |
| lag_b | input | 4 | Delay code for op_b |
| lag_c | input | 4 | Delay code for op_c |
| lag_d | input | 4 | Delay code for op_d |
| cke_a | input | 1 | Shift enable of the op_a delay line |
| cke_b | input | 1 | Shift enable of the op_b delay line |
| cke_c | input | 1 | Shift enable of the op_c delay line |
| cke_d | input | 1 | Shift enable of the op_d delay line |
| inv_p0 | input | 1 | Subtract product 0 instead of adding it |
| inv_p1 | input | 1 | Subtract product 1 instead of adding it |
| round_en | input | 1 | Add 2^7 to the sum |
| accum_en | input | 1 | 1: add onto accumulator, 0: load |
| chain_en | input | 1 | Add chain_in |
| chain_in | input | 16 | Signed chaining / offset input |
| hi_word | input | 1 | Output window: 1 upper (23:8), 0 lower (15:0) |
| out_en | input | 1 | Output enable, acts combinationally |
| out_word | output | 16 | Selected accumulator window, 0 when disabled |
| out_vld | output | 1 | High when out_en is high |

## Verification
An operand captured with lag code c reaches the accumulator after edge c+3. Controls reach it one edge after they are sampled. A window switch shows after one edge, and the output enable shows at once. In the full sweep, every input is held for four edges before the lower word is read. The bench then switches the window, waits one more edge and reads the upper word. In the delay sweep, a single-cycle pulse is sent through every lag code, and each following cycle is checked so that the pulse is seen exactly once, after edge c+3. In the accumulate test, the output is read after every edge, with the running sum computed for that edge in the bench.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  typedef struct packed {
    logic inv0;
    logic inv1;
    logic rnd;
    logic accum;
    logic chain;
  } mix_ctl_t;

  localparam mix_ctl_t MIX_CTL_IDLE = '{inv0: 1'b0, inv1: 1'b0, rnd: 1'b0,
                                        accum: 1'b0, chain: 1'b0};

endpackage

// File: rtl/mix_delay_line.sv
module mix_delay_line #(
  parameter int W    = 12,
  parameter int TAPS = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic [W-1:0]    din,
  input  logic [SELW-1:0] sel,
  output logic [W-1:0]    dout
);

  logic [W-1:0] stg [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) stg[i] <= '0;
    end else if (cke) begin
      stg[0] <= din;
      for (int i = 1; i < TAPS; i++) stg[i] <= stg[i-1];
    end
  end

  // tap k holds the operand captured k+1 edges ago
  assign dout = stg[sel];

endmodule

// File: rtl/mix_product.sv
module mix_product #(
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  logic [2*W-1:0] a_x, b_x;

  // sign-extend both, keep the low 2W bits: equals the signed product
  assign a_x = {{W{a[W-1]}}, a};
  assign b_x = {{W{b[W-1]}}, b};

  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else     p <= a_x * b_x;
  end

endmodule

// File: rtl/mix_accum.sv
module mix_accum
  import mixer_pkg::*;
#(
  parameter int PRW  = 24,
  parameter int WINW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PRW-1:0]  p0,
  input  logic [PRW-1:0]  p1,
  input  mix_ctl_t        ctl,
  input  logic [WINW-1:0] chain,
  output logic [PRW-1:0]  acc
);

  localparam int RBIT = PRW - WINW - 1;

  logic [PRW-1:0] t0, t1, t_chain, t_rnd, t_base, nxt;

  always_comb begin
    t0      = ctl.inv0  ? (~p0 + 1'b1) : p0;
    t1      = ctl.inv1  ? (~p1 + 1'b1) : p1;
    t_chain = ctl.chain ? {{(PRW-WINW){chain[WINW-1]}}, chain} : '0;
    t_rnd   = ctl.rnd   ? (PRW'(1) << RBIT) : '0;
    t_base  = ctl.accum ? acc : '0;
    nxt     = t_base + t0 + t1 + t_chain + t_rnd;
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= nxt;
  end

endmodule

// File: rtl/mix_window.sv
module mix_window #(
  parameter int PRW  = 24,
  parameter int WINW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PRW-1:0]  acc,
  input  logic            hi_sel,
  input  logic            oe,
  output logic [WINW-1:0] word,
  output logic            vld
);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= hi_sel;
  end

  always_comb begin
    word = '0;
    if (oe) word = sel_q ? acc[PRW-1 -: WINW] : acc[WINW-1:0];
  end

  assign vld = oe;

endmodule

// File: rtl/dual_mixer_core.sv
module dual_mixer_core
  import mixer_pkg::*;
#(
  parameter int OPW  = 12,
  parameter int TAPS = 16,
  parameter int WINW = 16,
  localparam int CODEW = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int PRW   = 2 * OPW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  logic [OPW-1:0]   op_c,
  input  logic [OPW-1:0]   op_d,
  input  logic [CODEW-1:0] lag_a,
  input  logic [CODEW-1:0] lag_b,
  input  logic [CODEW-1:0] lag_c,
  input  logic [CODEW-1:0] lag_d,
  input  logic             cke_a,
  input  logic             cke_b,
  input  logic             cke_c,
  input  logic             cke_d,
  input  logic             inv_p0,
  input  logic             inv_p1,
  input  logic             round_en,
  input  logic             accum_en,
  input  logic             chain_en,
  input  logic [WINW-1:0]  chain_in,
  input  logic             hi_word,
  input  logic             out_en,
  output logic [WINW-1:0]  out_word,
  output logic             out_vld
);

  localparam int NPORT = 4;
  localparam int NPROD = NPORT / 2;

  logic [OPW-1:0]   op_v  [NPORT];
  logic [CODEW-1:0] lag_v [NPORT];
  logic             cke_v [NPORT];
  logic [OPW-1:0]   tap   [NPORT];
  logic [PRW-1:0]   prod  [NPROD];
  logic [PRW-1:0]   acc_val;
  mix_ctl_t         ctl_d, ctl_q;
  logic [WINW-1:0]  chain_q;

  assign op_v[0]  = op_a;  assign op_v[1]  = op_b;
  assign op_v[2]  = op_c;  assign op_v[3]  = op_d;
  assign lag_v[0] = lag_a; assign lag_v[1] = lag_b;
  assign lag_v[2] = lag_c; assign lag_v[3] = lag_d;
  assign cke_v[0] = cke_a; assign cke_v[1] = cke_b;
  assign cke_v[2] = cke_c; assign cke_v[3] = cke_d;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      mix_delay_line #(.W(OPW), .TAPS(TAPS), .SELW(CODEW)) u_dl (
        .clk (clk),
        .rst (rst),
        .cke (cke_v[g]),
        .din (op_v[g]),
        .sel (lag_v[g]),
        .dout(tap[g])
      );
    end
    for (genvar m = 0; m < NPROD; m++) begin : g_mul
      mix_product #(.W(OPW)) u_mul (
        .clk(clk),
        .rst(rst),
        .a  (tap[2*m]),
        .b  (tap[2*m+1]),
        .p  (prod[m])
      );
    end
  endgenerate

  always_comb begin
    ctl_d       = MIX_CTL_IDLE;
    ctl_d.inv0  = inv_p0;
    ctl_d.inv1  = inv_p1;
    ctl_d.rnd   = round_en;
    ctl_d.accum = accum_en;
    ctl_d.chain = chain_en;
  end

  // controls travel alongside the products they act on
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= MIX_CTL_IDLE;
      chain_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      chain_q <= chain_in;
    end
  end

  mix_accum #(.PRW(PRW), .WINW(WINW)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .p0   (prod[0]),
    .p1   (prod[1]),
    .ctl  (ctl_q),
    .chain(chain_q),
    .acc  (acc_val)
  );

  mix_window #(.PRW(PRW), .WINW(WINW)) u_win (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc_val),
    .hi_sel(hi_word),
    .oe    (out_en),
    .word  (out_word),
    .vld   (out_vld)
  );

endmodule

// File: rtl/mix_checker.sv
module mix_checker #(
  parameter int OPW   = 12,
  parameter int PRW   = 24,
  parameter int WINW  = 16,
  parameter int CODEW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             out_en,
  input logic             out_vld,
  input logic [WINW-1:0]  out_word,
  input logic             hi_word,
  input logic             cke_a,
  input logic [CODEW-1:0] lag_a,
  input logic [OPW-1:0]   tap_a,
  input logic [PRW-1:0]   acc_q
);

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> acc_q == '0);  // R9

  AST_OE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> (out_word == '0 && !out_vld));  // R8

  AST_WIN_HI: assert property (@(posedge clk) disable iff (rst)
    (out_en && !$past(rst) && $past(hi_word)) |-> out_word == acc_q[PRW-1 -: WINW]);  // R7

  AST_WIN_LO: assert property (@(posedge clk) disable iff (rst)
    (out_en && !$past(rst) && !$past(hi_word)) |-> out_word == acc_q[WINW-1:0]);  // R7

  AST_FREEZE_A: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cke_a) && $stable(lag_a)) |-> $stable(tap_a));  // R3

endmodule

bind dual_mixer_core mix_checker #(
  .OPW(OPW), .PRW(PRW), .WINW(WINW), .CODEW(CODEW)
) u_mix_chk (
  .clk     (clk),
  .rst     (rst),
  .out_en  (out_en),
  .out_vld (out_vld),
  .out_word(out_word),
  .hi_word (hi_word),
  .cke_a   (cke_a),
  .lag_a   (lag_a),
  .tap_a   (tap[0]),
  .acc_q   (acc_val)
);

// File: tb/dual_mixer_core_bench.sv
module dual_mixer_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic [3:0]  lag_a = '0, lag_b = '0, lag_c = '0, lag_d = '0;
  logic        cke_a = 1'b1, cke_b = 1'b1, cke_c = 1'b1, cke_d = 1'b1;
  logic        inv_p0 = 1'b0, inv_p1 = 1'b0, round_en = 1'b0;
  logic        accum_en = 1'b0, chain_en = 1'b0;
  logic [15:0] chain_in = '0;
  logic        hi_word = 1'b0, out_en = 1'b1;
  logic [15:0] out_word;
  logic        out_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dual_mixer_core u_dual_mixer_core (
    .clk(clk), .rst(rst),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .lag_a(lag_a), .lag_b(lag_b), .lag_c(lag_c), .lag_d(lag_d),
    .cke_a(cke_a), .cke_b(cke_b), .cke_c(cke_c), .cke_d(cke_d),
    .inv_p0(inv_p0), .inv_p1(inv_p1), .round_en(round_en),
    .accum_en(accum_en), .chain_en(chain_en), .chain_in(chain_in),
    .hi_word(hi_word), .out_en(out_en),
    .out_word(out_word), .out_vld(out_vld)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [23:0] model(input int a, input int b, input int c, input int d,
                                        input bit n0, input bit n1, input bit r,
                                        input bit ce, input logic [15:0] s);
    int p0, p1, t;
    p0 = a * b;
    p1 = c * d;
    t  = (n0 ? -p0 : p0) + (n1 ? -p1 : p1);
    if (ce) t = t + int'($signed(s));
    if (r)  t = t + 128;
    return t[23:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int vals [7] = '{-2048, -1, 0, 1, 2047, 5, -300};
    logic [15:0] chains [4] = '{16'h0000, 16'h7fff, 16'h8000, 16'h1234};
    longint vsq;
    int idx;
    logic [23:0] e;

    // R9: reset state
    tick(3);
    rst = 1'b0;
    check("R9 reset lo", {8'h0, out_word}, 24'h0);
    check("R8 vld after reset", {23'h0, out_vld}, 24'h1);
    hi_word = 1'b1;
    tick(1);
    check("R9 reset hi", {8'h0, out_word}, 24'h0);
    hi_word = 1'b0;

    // R2: pulse through each lag code on port a
    op_b = 12'd1;
    for (int d = 0; d < 16; d++) begin
      lag_a = d[3:0];
      op_a  = '0;
      tick(20);
      op_a = 12'd777;
      for (int k = 1; k <= d + 6; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (k == 1) op_a = '0;
        check("R2 lag pulse", {8'h0, out_word}, (k == d + 3) ? 24'd777 : 24'd0);
      end
    end
    lag_a = '0;

    // R3: freeze port a
    op_a = 12'd100; op_b = 12'd3;
    tick(5);
    check("R3 before freeze", {8'h0, out_word}, 24'd300);
    cke_a = 1'b0;
    op_a  = -12'sd50;
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      check("R3 frozen", {8'h0, out_word}, 24'd300);
    end
    cke_a = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick(1);
      check("R3 resume", {8'h0, out_word}, (k < 3) ? 24'd300 : {8'h0, 16'hff6a});
    end

    // R4 / R10: accumulate with wrap, watched on the upper word
    op_a = 12'd2047; op_b = 12'd2047;
    hi_word = 1'b1;
    tick(5);
    vsq = 64'd4190209;
    check("R4 load", {8'h0, out_word}, 24'(vsq >> 8));
    accum_en = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      check("R4 R10 accumulate", {8'h0, out_word}, 24'(((vsq * k) % 64'd16777216) >> 8));
    end
    accum_en = 1'b0;
    tick(1);
    check("R4 last add", {8'h0, out_word}, 24'(((vsq * 9) % 64'd16777216) >> 8));
    tick(1);
    check("R4 reload", {8'h0, out_word}, 24'(vsq >> 8));

    // R9: reset in mid-run
    accum_en = 1'b1;
    tick(3);
    rst = 1'b1;
    tick(1);
    check("R9 mid reset", {8'h0, out_word}, 24'h0);
    rst = 1'b0;
    accum_en = 1'b0;
    hi_word  = 1'b0;

    // R7: window switch; -1000000 = 24'hF0BDC0
    op_a = 12'd1000; op_b = -12'sd1000;
    tick(5);
    check("R7 lo word", {8'h0, out_word}, 24'h00bdc0);
    hi_word = 1'b1;
    #1;
    check("R7 no switch before edge", {8'h0, out_word}, 24'h00bdc0);
    tick(1);
    check("R7 hi word", {8'h0, out_word}, 24'h00f0bd);

    // R8: output enable
    out_en = 1'b0;
    #1;
    check("R8 word off", {8'h0, out_word}, 24'h0);
    check("R8 vld off", {23'h0, out_vld}, 24'h0);
    out_en = 1'b1;
    #1;
    check("R8 word on", {8'h0, out_word}, 24'h00f0bd);
    check("R8 vld on", {23'h0, out_vld}, 24'h1);
    tick(1);

    // R1 R5 R6 R10: operand and control sweep
    idx = 0;
    for (int ia = 0; ia < 7; ia++)
      for (int ib = 0; ib < 7; ib++)
        for (int ic = 0; ic < 7; ic++)
          for (int id = 0; id < 7; id++) begin
            op_a = 12'(vals[ia]); op_b = 12'(vals[ib]);
            op_c = 12'(vals[ic]); op_d = 12'(vals[id]);
            inv_p0   = idx[0];
            inv_p1   = idx[1];
            round_en = idx[2];
            chain_en = idx[3];
            chain_in = chains[(idx >> 4) & 3];
            hi_word  = 1'b0;
            e = model(vals[ia], vals[ib], vals[ic], vals[id],
                      idx[0], idx[1], idx[2], idx[3], chains[(idx >> 4) & 3]);
            tick(4);
            check("R1 R5 R6 R10 sweep lo", {8'h0, out_word}, {8'h0, e[15:0]});
            hi_word = 1'b1;
            tick(1);
            check("R1 R5 R6 R10 sweep hi", {8'h0, out_word}, {8'h0, e[23:8]});
            idx++;
          end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule